// File: doc/BRIEF.md
# Pulse-Skipping Overcurrent Limiter

This block sits between a fixed-frequency PWM modulator and the gate driver of a high-side power switch. Each switching period starts with a one-clock tick. While the modulator's on-request is high, the block passes it to the drive output. A comparator flag reports when the switch current exceeds its limit. The block ignores that flag for a blanking interval at the start of every on-time, so that switching noise cannot cause a false trip. Once blanking is over, an overcurrent ends the pulse at once.

A saturating skip level sets the response to a sustained fault. Each period that ends in overcurrent raises the level by one and then suppresses that many whole periods. Each on-time that is still clean when blanking ends lowers the level by one. Under a sustained short the switching frequency therefore falls in steps, down to one eighth of nominal at the top level. It recovers in steps when the fault clears. The blanking length and the maximum skip level are parameters given in system-clock cycles and periods.

Top module: `ocp_pulse_limiter`

## Requirements
- R1: After reset, a period whose on-request lasts longer than the blanking interval and sees no overcurrent drives the switch on every clock that the request is high, except the tick clock.
- R2: drive_o is high only in clocks where pwm_req_i is high.
- R3: During the first BLANK_CYC clocks of drive in a period, oc_flag_i has no effect on drive_o or on the skip level.
- R4: If oc_flag_i is high in any driven clock after blanking, drive_o goes low in that same clock and stays low until the next tick. That period counts as an overcurrent period.
- R5: A period that ends in overcurrent is followed by exactly N skipped periods, where N is the updated skip level. In a skipped period drive_o stays low for the whole period, whatever the on-request.
- R6: Each overcurrent period raises the skip level by one, saturating at MAX_SKIP (7). At saturation, only one period in eight is driven.
- R7: A period whose drive passes the end of blanking with oc_flag_i low, and which has no later overcurrent, lowers the skip level by one, with a floor of zero. The period after it is not skipped.
- R8: A period whose on-request ends before blanking completes leaves the skip level unchanged.
- R9: drive_o is low in every clock where cycle_tick_i is high.
- R10: The active-low asynchronous reset clears the skip level and any pending skipped periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cycle_tick_i | input | 1 | One-clock pulse that starts a switching period |
| pwm_req_i | input | 1 | On-request from the PWM modulator |
| oc_flag_i | input | 1 | Comparator flag: switch current is above the limit |
| drive_o | output | 1 | Gated drive for the high-side switch |

## Verification
The bench drives periods of four kinds:
- Clean long pulses show how the level falls and where the zero floor lies.
- Overcurrent that starts inside blanking shows that the cut lands exactly at the blanking boundary.
- Overcurrent that starts well after blanking shows that the cut follows the flag.
- A short pulse with the flag high from its first clock shows that an unevaluated period leaves the level unchanged.

Runs of back-to-back overcurrent periods reveal the level through the number of fully dark periods that follow. These runs continue until the level saturates and the output reaches one driven period in eight. A reset in the middle of a skip run shows that the pending skips are dropped. The request is also held high across every tick, which shows that the tick clock is gated.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    OUT_NONE  = 2'd0,
    OUT_CLEAN = 2'd1,
    OUT_OC    = 2'd2
  } outcome_e;
endpackage

// File: rtl/ocp_blank_timer.sv
module ocp_blank_timer #(
  parameter int BLANK_CYC = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(BLANK_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q == CNT_W'(BLANK_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (run_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ocp_skip_ctrl.sv
module ocp_skip_ctrl
  import ocp_pkg::*;
#(
  parameter int MAX_SKIP = 7
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             tick_i,
  input  outcome_e                         outcome_i,
  output logic                             skipping_o,
  output logic [$clog2(MAX_SKIP+1)-1:0]    level_o
);
  localparam int LVL_W = $clog2(MAX_SKIP + 1);

  logic [LVL_W-1:0] level_q, level_up, skip_left_q;
  logic             skipping_q;

  assign level_up   = (level_q == LVL_W'(MAX_SKIP)) ? level_q : level_q + 1'b1;
  assign skipping_o = skipping_q;
  assign level_o    = level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q     <= '0;
      skip_left_q <= '0;
      skipping_q  <= 1'b0;
    end else if (tick_i) begin
      if (skipping_q) begin
        if (skip_left_q != '0) skip_left_q <= skip_left_q - 1'b1;
        else                   skipping_q  <= 1'b0;
      end else if (outcome_i == OUT_OC) begin
        level_q     <= level_up;
        skipping_q  <= 1'b1;
        skip_left_q <= level_up - 1'b1; // current tick starts the first skip
      end else if (outcome_i == OUT_CLEAN && level_q != '0) begin
        level_q <= level_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ocp_pulse_limiter.sv
module ocp_pulse_limiter
  import ocp_pkg::*;
#(
  parameter int BLANK_CYC = 25,
  parameter int MAX_SKIP  = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cycle_tick_i,
  input  logic pwm_req_i,
  input  logic oc_flag_i,
  output logic drive_o
);
  localparam int LVL_W = $clog2(MAX_SKIP + 1);

  logic             skipping, blank_done, drive_en, oc_cut;
  logic             term_q, clean_q;
  logic [LVL_W-1:0] level;
  outcome_e         outcome;

  assign drive_en = pwm_req_i & ~cycle_tick_i & ~skipping & ~term_q;
  assign oc_cut   = drive_en & blank_done & oc_flag_i;
  assign drive_o  = drive_en & ~oc_cut;

  ocp_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cycle_tick_i),
    .run_i (drive_en),
    .done_o(blank_done)
  );

  // per-period evaluation result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      term_q  <= 1'b0;
      clean_q <= 1'b0;
    end else if (cycle_tick_i) begin
      term_q  <= 1'b0;
      clean_q <= 1'b0;
    end else begin
      if (oc_cut) term_q <= 1'b1;
      if (drive_en && blank_done && !oc_flag_i) clean_q <= 1'b1;
    end
  end

  always_comb begin
    if (term_q)       outcome = OUT_OC;
    else if (clean_q) outcome = OUT_CLEAN;
    else              outcome = OUT_NONE;
  end

  ocp_skip_ctrl #(.MAX_SKIP(MAX_SKIP)) u_skip (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (cycle_tick_i),
    .outcome_i (outcome),
    .skipping_o(skipping),
    .level_o   (level)
  );
endmodule

// File: rtl/ocp_limiter_chk.sv
module ocp_limiter_chk #(
  parameter int MAX_SKIP = 7,
  parameter int LVL_W    = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cycle_tick_i,
  input logic             pwm_req_i,
  input logic             oc_flag_i,
  input logic             drive_o,
  input logic             skipping,
  input logic             term_q,
  input logic             clean_q,
  input logic [LVL_W-1:0] level
);
  p_req_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> pwm_req_i);

  p_tick_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_tick_i |-> !drive_o);

  p_skip_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skipping |-> !drive_o);

  p_oc_then_skip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_tick_i && term_q && !skipping) |=> skipping);

  p_cut_needs_oc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(drive_o) && pwm_req_i && $past(pwm_req_i) && !cycle_tick_i && !skipping)
      |-> oc_flag_i);

  p_level_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cycle_tick_i |=> $stable(level));

  p_level_inc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_tick_i && term_q && !skipping && level != LVL_W'(MAX_SKIP))
      |=> level == LVL_W'($past(level) + 1'b1));

  p_level_dec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_tick_i && clean_q && !term_q && !skipping && level != '0)
      |=> level == LVL_W'($past(level) - 1'b1));
endmodule

bind ocp_pulse_limiter ocp_limiter_chk #(
  .MAX_SKIP(MAX_SKIP),
  .LVL_W   (LVL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cycle_tick_i(cycle_tick_i),
  .pwm_req_i   (pwm_req_i),
  .oc_flag_i   (oc_flag_i),
  .drive_o     (drive_o),
  .skipping    (skipping),
  .term_q      (term_q),
  .clean_q     (clean_q),
  .level       (level)
);

// File: tb/tb_ocp_pulse_limiter.sv
module tb_ocp_pulse_limiter;
  localparam int BLANK = 25;
  localparam int MAXS  = 7;
  localparam int PER   = 60;

  logic clk = 1'b0, rst_ni = 1'b0, tick = 1'b0, pwm = 1'b0, oc = 1'b0;
  logic drive;

  always #4 clk = ~clk;

  ocp_pulse_limiter #(.BLANK_CYC(BLANK), .MAX_SKIP(MAXS)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cycle_tick_i(tick),
    .pwm_req_i(pwm), .oc_flag_i(oc), .drive_o(drive)
  );

  typedef struct { int cnt; string tag; } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  int lvl_m = 0, skip_m = 0;
  int cur_cnt = 0;
  bit seen_tick = 0;
  int r2_bad = 0, r9_bad = 0;

  // monitor: count driven clocks per period, compare at each tick
  always @(negedge clk) begin
    if (!rst_ni) begin
      seen_tick = 0;
      cur_cnt   = 0;
    end else begin
      if (drive && !pwm) r2_bad++;
      if (drive && tick) r9_bad++;
      if (tick) begin
        if (seen_tick) begin
          if (q.size() == 0) begin
            checks++; fails++;
            $display("FAIL scoreboard empty: actual %0d expected none", cur_cnt);
          end else begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (e.cnt != cur_cnt) begin
              fails++;
              $display("FAIL %s: driven clocks actual %0d expected %0d", e.tag, cur_cnt, e.cnt);
            end
          end
        end
        seen_tick = 1;
        cur_cnt   = 0;
      end else if (drive) begin
        cur_cnt++;
      end
    end
  end

  // driver: on-request high clocks 0..len, overcurrent from on-offset k (k<0: none)
  task automatic run_period(int len, int k, string tag);
    exp_t e;
    e.tag = tag;
    if (skip_m > 0) begin
      e.cnt = 0;
      skip_m--;
    end else begin
      int t;
      t = (k > BLANK) ? k : BLANK;
      if (k >= 0 && t < len) begin
        e.cnt = t;
        lvl_m = (lvl_m < MAXS) ? lvl_m + 1 : MAXS;
        skip_m = lvl_m;
      end else begin
        e.cnt = len;
        if (len > BLANK && lvl_m > 0) lvl_m--;
      end
    end
    q.push_back(e);
    for (int c = 0; c < PER; c++) begin
      @(posedge clk); #1;
      tick = (c == 0);
      pwm  = (c <= len) && (len > 0);
      oc   = (k >= 0) && (c >= k + 1) && (c <= len);
    end
  endtask

  task automatic close_period();
    @(posedge clk); #1;
    tick = 1'b1; pwm = 1'b0; oc = 1'b0;
    @(posedge clk); #1;
    tick = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic finish_run();
    checks++;
    if (r2_bad != 0) begin
      fails++;
      $display("FAIL R2: drive without request actual %0d expected 0", r2_bad);
    end
    checks++;
    if (r9_bad != 0) begin
      fails++;
      $display("FAIL R9: drive on tick clock actual %0d expected 0", r9_bad);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R1 clean after reset, R7 floor at zero
    run_period(40, -1, "R1");
    run_period(40, -1, "R7");
    // R3 overcurrent inside blanking is cut at the boundary
    run_period(40, 5, "R3");
    run_period(40, -1, "R5");
    // R4 late overcurrent cut at its own clock
    run_period(40, 30, "R4");
    while (skip_m > 0) run_period(40, -1, "R5");
    // R6 climb to saturation
    for (int i = 0; i < 7; i++) begin
      run_period(40, BLANK, "R6");
      while (skip_m > 0) run_period(40, -1, "R6");
    end
    // R7 recovery steps
    run_period(40, -1, "R7");
    run_period(40, -1, "R7");
    // R8 short pulse with flag high leaves level alone
    run_period(10, 0, "R8");
    run_period(40, BLANK, "R8");
    while (skip_m > 0) run_period(40, -1, "R8");
    // R10 reset in the middle of a skip run
    run_period(40, BLANK, "R10");
    close_period();
    rst_ni = 1'b0;
    lvl_m = 0; skip_m = 0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    run_period(40, -1, "R10");
    run_period(40, BLANK, "R10");
    while (skip_m > 0) run_period(40, -1, "R10");
    run_period(40, -1, "R7");
    close_period();
    finish_run();
  end
endmodule